// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block walks a ring of receive descriptors kept in memory on behalf of a packet receiver. Software fills a 1 kB-aligned table with two-word descriptors. Word 0 carries the control and status bits, and word 1 carries a buffer address. Software then writes the table position into the pointer register and turns reception on in the control register. The block reads the descriptor at the current index. If the descriptor is enabled, the block presents the buffer address to the receive data path and waits for that path to report the end of a frame.

When the frame-done strobe arrives, the block writes word 0 back in a single write. The written word holds the received byte count, the thirteen status and detection flags, and the original wrap and interrupt-enable bits, with the enable bit cleared so that software owns the descriptor again. Once the memory acknowledges that write, the index either moves to the next 8-byte slot or returns to slot zero. An interrupt pulse may be issued at the same time.

A descriptor found disabled stops the ring on its index. The block fetches that descriptor again only when software rewrites the pointer register or writes the control register with reception enabled.

Top module: `rxd_ring_ctrl`

## Requirements
- R1: Register port: with `reg_sel_ptr`=1 the pointer register is selected. A write stores `reg_wdata[31:10]` as the table base and `reg_wdata[9:3]` as the descriptor index. The value read back is {base, index, 3'b000}. With `reg_sel_ptr`=0 the control register is selected: bit 0 enables reception and bit 1 enables the receive interrupt. `reg_rdata` follows the select one clock later. Both registers reset to zero.
- R2: No memory request is issued unless reception is enabled and the pointer register has been written since reset.
- R3: A fetch reads word 0 at {base, index, 000}. If word 0 bit 11 (enable) is 1, the block then reads word 1 at that address + 4. It then holds `buf_valid` high with `buf_addr` equal to word 1 until a frame completes.
- R4: If fetched word 0 has bit 11 clear, word 1 is not read and `buf_valid` stays low. The block stays on that index. It reads word 0 again, exactly once, after an accepted pointer write or a control write with bit 0 set.
- R5: Completion produces one memory write to the word 0 address. The written data is: bits 10..0 the frame length, bit 11 zero, bit 12 the fetched wrap bit, bit 13 the fetched interrupt-enable bit, bits 26..14 the frame flags (flag bit 0 at bit 14), and bits 31..27 zero.
- R6: After the write-back is acknowledged, the index increases by one, which is 8 bytes.
- R7: If the fetched descriptor had wrap (bit 12) set, the index returns to 0 instead of increasing.
- R8: Advancing from index 127 returns the index to 0, so the 1 kB table boundary is never crossed.
- R9: `rx_irq` pulses for exactly one cycle, in the cycle after the write-back acknowledge, when the fetched bit 13 and control bit 1 are both 1. It does so whatever the flags are, and it does not pulse otherwise.
- R10: Pointer writes are ignored while a descriptor is being fetched, is in use, or is being written back.
- R11: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack`.
- R12: `frm_done` has no effect while `buf_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel_ptr | input | 1 | Register select: 1 pointer, 0 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write-back, 0 for descriptor read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory acknowledge; carries read data for reads |
| mem_rdata | input | 32 | Memory read data |
| buf_valid | output | 1 | A valid descriptor is ready for a frame |
| buf_addr | output | 32 | Buffer address from descriptor word 1 |
| frm_done | input | 1 | Frame finished strobe |
| frm_len | input | 11 | Bytes received for the frame |
| frm_flags | input | 13 | Status and detection flags of the frame |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The bench covers the following cases, and what a faulty design would do in each:
- **Three index outcomes.** A plain step, a step forced by the wrap bit, and the step from slot 127. A design that ignored the wrap bit, or carried into the base field, would read the pointer back at the wrong slot.
- **Write-back word contents.** A wrong field position in the written word shows up as a bit mismatch against a word the bench builds itself. So does an enable bit that is left set.
- **Parked ring.** The bench parks the ring on a disabled descriptor. A design that read word 1 anyway, re-read more than once on a kick, or reacted to a stray frame strobe would change the read or write counts.
- **Gating and ignored inputs.** The bench checks interrupt gating from both enable bits. It also checks that a pointer write made in mid-frame is rejected, so that the write-back still lands on the descriptor that was fetched.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int WORD_W   = 32;
  localparam int LEN_W    = 11;
  localparam int FLAG_W   = 13;

  // word 0 bit positions (decoded by software, so fixed)
  localparam int EN_BIT   = 11;
  localparam int WR_BIT   = 12;
  localparam int IE_BIT   = 13;
  localparam int FLAG_LSB = 14;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD0,
    S_RD1,
    S_READY,
    S_WB,
    S_PARK
  } seq_st_e;

  // status word returned to software: ownership bit cleared
  function automatic logic [WORD_W-1:0] pack_status(
    input logic [LEN_W-1:0]  len,
    input logic [FLAG_W-1:0] flg,
    input logic              ie,
    input logic              wr
  );
    logic [WORD_W-1:0] w;
    w                     = '0;
    w[LEN_W-1:0]          = len;
    w[EN_BIT]             = 1'b0;
    w[WR_BIT]             = wr;
    w[IE_BIT]             = ie;
    w[FLAG_LSB +: FLAG_W] = flg;
    return w;
  endfunction

endpackage

// File: rtl/rxd_ptr_regs.sv
module rxd_ptr_regs
  import rxd_pkg::*;
#(
  parameter  int TBL_LOG2  = 10,
  parameter  int DESC_LOG2 = 3,
  localparam int IDX_W     = TBL_LOG2 - DESC_LOG2,
  localparam int BASE_W    = WORD_W - TBL_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              sel_ptr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ptr_allow,
  input  logic              adv,
  input  logic              wrap_req,
  output logic [WORD_W-1:0] rdata,
  output logic              rx_en,
  output logic              irq_en,
  output logic              ptr_valid,
  output logic [BASE_W-1:0] base,
  output logic [IDX_W-1:0]  idx,
  output logic              kick
);

  localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

  logic ptr_wr;
  logic ctl_wr;

  assign ptr_wr = wr_en && sel_ptr && ptr_allow;
  assign ctl_wr = wr_en && !sel_ptr;
  assign kick   = ptr_wr || (ctl_wr && wdata[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en     <= 1'b0;
      irq_en    <= 1'b0;
      ptr_valid <= 1'b0;
      base      <= '0;
      idx       <= '0;
      rdata     <= '0;
    end else begin
      if (ctl_wr) begin
        rx_en  <= wdata[0];
        irq_en <= wdata[1];
      end
      if (ptr_wr) begin
        base      <= wdata[WORD_W-1:TBL_LOG2];
        idx       <= wdata[TBL_LOG2-1:DESC_LOG2];
        ptr_valid <= 1'b1;
      end else if (adv) begin
        idx <= (wrap_req || idx == IDX_LAST) ? '0 : idx + IDX_W'(1);
      end
      rdata <= sel_ptr ? {base, idx, {DESC_LOG2{1'b0}}}
                       : {{(WORD_W-2){1'b0}}, irq_en, rx_en};
    end
  end

endmodule

// File: rtl/rxd_seq.sv
module rxd_seq
  import rxd_pkg::*;
#(
  parameter  int TBL_LOG2  = 10,
  parameter  int DESC_LOG2 = 3,
  localparam int IDX_W     = TBL_LOG2 - DESC_LOG2,
  localparam int BASE_W    = WORD_W - TBL_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              irq_en,
  input  logic              ptr_valid,
  input  logic              kick,
  input  logic [BASE_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              frm_done,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [FLAG_W-1:0] frm_flags,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              buf_valid,
  output logic [WORD_W-1:0] buf_addr,
  output logic              adv,
  output logic              wrap_req,
  output logic              ptr_allow,
  output logic              irq
);

  seq_st_e           st;
  logic              wr_q;
  logic              ie_q;
  logic [LEN_W-1:0]  len_q;
  logic [FLAG_W-1:0] flg_q;
  logic [WORD_W-1:0] desc_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      wr_q     <= 1'b0;
      ie_q     <= 1'b0;
      len_q    <= '0;
      flg_q    <= '0;
      buf_addr <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (st)
        S_IDLE:  if (rx_en && ptr_valid) st <= S_RD0;
        S_RD0:   if (mem_ack) begin
                   wr_q <= mem_rdata[WR_BIT];
                   ie_q <= mem_rdata[IE_BIT];
                   st   <= mem_rdata[EN_BIT] ? S_RD1 : S_PARK;
                 end
        S_RD1:   if (mem_ack) begin
                   buf_addr <= mem_rdata;
                   st       <= S_READY;
                 end
        S_READY: if (frm_done) begin
                   len_q <= frm_len;
                   flg_q <= frm_flags;
                   st    <= S_WB;
                 end
        S_WB:    if (mem_ack) begin
                   irq <= ie_q && irq_en;
                   st  <= S_IDLE;
                 end
        S_PARK:  if (kick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // bus signals are decoded straight from registered state
  assign desc_addr = {base, idx, {DESC_LOG2{1'b0}}};
  assign mem_req   = (st == S_RD0) || (st == S_RD1) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_RD1) ? desc_addr + WORD_W'(4) : desc_addr;
  assign mem_wdata = pack_status(len_q, flg_q, ie_q, wr_q);
  assign buf_valid = (st == S_READY);
  assign adv       = (st == S_WB) && mem_ack;
  assign wrap_req  = wr_q;
  assign ptr_allow = (st == S_IDLE) || (st == S_PARK);

endmodule

// File: rtl/rxd_ring_ctrl.sv
module rxd_ring_ctrl
  import rxd_pkg::*;
#(
  parameter  int TBL_LOG2  = 10,
  parameter  int DESC_LOG2 = 3,
  localparam int IDX_W     = TBL_LOG2 - DESC_LOG2,
  localparam int BASE_W    = WORD_W - TBL_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel_ptr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              buf_valid,
  output logic [WORD_W-1:0] buf_addr,
  input  logic              frm_done,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [FLAG_W-1:0] frm_flags,
  output logic              rx_irq
);

  logic              ctl_rx_en;
  logic              ctl_irq_en;
  logic              ptr_valid;
  logic              kick;
  logic              adv;
  logic              wrap_req;
  logic              ptr_allow;
  logic [BASE_W-1:0] base;
  logic [IDX_W-1:0]  idx;

  rxd_ptr_regs #(
    .TBL_LOG2 (TBL_LOG2),
    .DESC_LOG2(DESC_LOG2)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr),
    .sel_ptr  (reg_sel_ptr),
    .wdata    (reg_wdata),
    .ptr_allow(ptr_allow),
    .adv      (adv),
    .wrap_req (wrap_req),
    .rdata    (reg_rdata),
    .rx_en    (ctl_rx_en),
    .irq_en   (ctl_irq_en),
    .ptr_valid(ptr_valid),
    .base     (base),
    .idx      (idx),
    .kick     (kick)
  );

  rxd_seq #(
    .TBL_LOG2 (TBL_LOG2),
    .DESC_LOG2(DESC_LOG2)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (ctl_rx_en),
    .irq_en   (ctl_irq_en),
    .ptr_valid(ptr_valid),
    .kick     (kick),
    .base     (base),
    .idx      (idx),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .frm_done (frm_done),
    .frm_len  (frm_len),
    .frm_flags(frm_flags),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .buf_valid(buf_valid),
    .buf_addr (buf_addr),
    .adv      (adv),
    .wrap_req (wrap_req),
    .ptr_allow(ptr_allow),
    .irq      (rx_irq)
  );

endmodule

// File: rtl/rxd_ring_chk.sv
module rxd_ring_chk
  import rxd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              buf_valid,
  input logic [WORD_W-1:0] buf_addr,
  input logic              frm_done,
  input logic              irq,
  input logic              irq_en
);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata));

  p_wb_owner_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !mem_wdata[EN_BIT] && mem_wdata[WORD_W-1:27] == '0);

  p_word_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);

  p_buf_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    buf_valid |-> !mem_req);

  p_buf_hold_r3: assert property (@(posedge clk) disable iff (rst)
    buf_valid && !frm_done |=> buf_valid && $stable(buf_addr));

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mem_req && mem_we && mem_ack) && irq_en);

endmodule

bind rxd_ring_ctrl rxd_ring_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .buf_valid(buf_valid),
  .buf_addr (buf_addr),
  .frm_done (frm_done),
  .irq      (rx_irq),
  .irq_en   (ctl_irq_en)
);

// File: tb/rxd_ring_ctrl_tb_top.sv
`timescale 1ns/1ps
module rxd_ring_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr = 1'b0;
  logic        reg_sel_ptr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        buf_valid;
  logic [31:0] buf_addr;
  logic        frm_done = 1'b0;
  logic [10:0] frm_len = '0;
  logic [12:0] frm_flags = '0;
  logic        rx_irq;

  always #2.5 clk = ~clk;

  rxd_ring_ctrl dut_i (.*);

  // memory model: acknowledge after two waiting cycles
  logic [31:0] mem [1024];
  int          lat = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          irq_cnt = 0;
  logic [31:0] last_wa = '0;
  logic [31:0] last_wd = '0;

  always @(negedge clk) begin
    if (rx_irq) irq_cnt++;
    if (mem_ack) begin
      mem_ack = 1'b0;
      lat     = 0;
    end else if (mem_req) begin
      if (lat == 2) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
          wr_cnt++;
          last_wa = mem_addr;
          last_wd = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
          rd_cnt++;
        end
      end else begin
        lat++;
      end
    end
  end

  int total = 0;
  int fails = 0;
  bit done  = 0;

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(bit sel, logic [31:0] d);
    reg_sel_ptr = sel; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(bit sel, output logic [31:0] d);
    reg_sel_ptr = sel;
    tick();
    d = reg_rdata;
  endtask

  task automatic put_desc(int idx, bit en, bit wr, bit ie);
    mem[256 + 2*idx] = {18'b0, ie, wr, en, 11'b0};
    mem[257 + 2*idx] = 32'hB000_0000 + idx * 16;
  endtask

  task automatic wait_bufv(output bit ok);
    ok = 0;
    for (int i = 0; i < 100 && !ok; i++) begin
      tick();
      if (buf_valid) ok = 1;
    end
  endtask

  task automatic wait_wr(int prev);
    for (int i = 0; i < 100 && wr_cnt == prev; i++) tick();
  endtask

  task automatic frame(logic [10:0] len, logic [12:0] flg);
    frm_len = len; frm_flags = flg; frm_done = 1'b1;
    tick();
    frm_done = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // fields: [31] wrap, [30] irq enable, [29:17] flags, [16:6] length
  localparam logic [31:0] VEC [5] = '{
    {1'b0, 1'b1, 13'h0000, 11'd64,   6'd0},
    {1'b0, 1'b0, 13'h1FFF, 11'd1500, 6'd0},
    {1'b1, 1'b1, 13'h0005, 11'd2047, 6'd0},
    {1'b0, 1'b1, 13'h1000, 11'd1,    6'd0},
    {1'b0, 1'b0, 13'h0AAA, 11'd0,    6'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] exp_w;
    bit          ok;
    int          idx, nidx, pw, pi, pr;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick();

    reg_read(1, rd);  check("R1 ptr reset", rd, 32'h0);
    reg_read(0, rd);  check("R1 ctrl reset", rd, 32'h0);
    check("R3 buf_valid reset", {31'b0, buf_valid}, 32'h0);
    check("R9 irq reset", {31'b0, rx_irq}, 32'h0);

    put_desc(0, 1, VEC[0][31], VEC[0][30]);
    reg_write(0, 32'h3);
    tick(20);
    check("R2 no fetch before pointer", rd_cnt, 0);
    reg_read(0, rd);  check("R1 ctrl readback", rd, 32'h3);
    reg_write(1, 32'h0000_0407);
    reg_read(1, rd);  check("R1 ptr readback", rd, 32'h0000_0400);

    idx = 0;
    for (int k = 0; k < 5; k++) begin
      logic        wr, ie;
      logic [12:0] flg;
      logic [10:0] len;
      wr  = VEC[k][31];
      ie  = VEC[k][30];
      flg = VEC[k][29:17];
      len = VEC[k][16:6];
      wait_bufv(ok);
      check("R3 buf_valid", {31'b0, ok}, 32'h1);
      check("R3 buf_addr", buf_addr, 32'hB000_0000 + idx * 16);
      nidx = wr ? 0 : ((idx == 127) ? 0 : idx + 1);
      if (k < 4) put_desc(nidx, 1, VEC[k+1][31], VEC[k+1][30]);
      else       put_desc(nidx, 0, 0, 0);
      pw = wr_cnt; pi = irq_cnt;
      frame(len, flg);
      wait_wr(pw);
      check("R5 write address", last_wa, 32'h400 + idx * 8);
      exp_w = {5'b0, flg, ie, wr, 1'b0, len};
      check("R5 write data", last_wd, exp_w);
      tick(3);
      check("R9 irq count", irq_cnt - pi, {31'b0, ie});
      reg_read(1, rd);
      if (wr) check("R7 wrap index", rd, 32'h400 + nidx * 8);
      else    check("R6 next index", rd, 32'h400 + nidx * 8);
      idx = nidx;
    end

    // ring parked at index 2 on a disabled descriptor
    tick(10);
    check("R4 parked no buffer", {31'b0, buf_valid}, 32'h0);
    pw = wr_cnt; pr = rd_cnt;
    frame(11'd5, 13'h0);
    tick(10);
    check("R12 stray frame ignored", wr_cnt, pw);
    reg_write(0, 32'h1);
    tick(15);
    check("R4 single refetch", rd_cnt - pr, 1);
    check("R4 still parked", {31'b0, buf_valid}, 32'h0);

    put_desc(127, 1, 0, 1);
    reg_write(1, 32'h400 | (127 << 3));
    wait_bufv(ok);
    check("R3 buf_valid slot 127", {31'b0, ok}, 32'h1);
    check("R3 buf_addr slot 127", buf_addr, 32'hB000_0000 + 127 * 16);
    reg_write(1, 32'h0000_0808);
    reg_read(1, rd);
    check("R10 pointer write ignored", rd, 32'h0000_07F8);
    pw = wr_cnt; pi = irq_cnt;
    frame(11'd33, 13'h0100);
    wait_wr(pw);
    check("R5 write address slot 127", last_wa, 32'h0000_07F8);
    check("R5 write data slot 127", last_wd, {5'b0, 13'h0100, 1'b1, 1'b0, 1'b0, 11'd33});
    tick(3);
    check("R9 irq gated off", irq_cnt - pi, 0);
    reg_read(1, rd);
    check("R8 boundary wrap", rd, 32'h0000_0400);
    tick(10);
    check("R4 returned word parks", {31'b0, buf_valid}, 32'h0);

    reg_write(0, 32'h0);
    put_desc(0, 1, 0, 0);
    pr = rd_cnt;
    reg_write(1, 32'h0000_0400);
    tick(15);
    check("R2 no fetch while disabled", rd_cnt, pr);

    summary();
  end

endmodule